// File: doc/BRIEF.md
# Transfer-Group Buffer Sequencer

This block steps through one transfer group, a contiguous run of entries in a serial-port buffer RAM, and launches one serial word for each entry. Every entry holds a 16-bit control word that gives its mode, chip-select code, chip-select hold, data format and delay enable. On each entry the sequencer sends the word, skips the entry, or stalls until the host side has refilled the transmit data or drained the receive data. When an entry asks for it, the sequencer holds a programmable gap after that entry's transfer.

A group begins at its own start field. It ends one entry before the start field of the next-higher group, and the highest group runs to the last RAM entry. A group is started by a trigger. In immediate mode, raising the group enable is the trigger. Otherwise an external trigger pulse starts it. The group then runs either once per trigger or repeatedly. The bit shifter is outside this block: the sequencer emits a start pulse with the entry's fields and waits for a done pulse.

Top module: `tgSequencer`

## Requirements
- R1: After reset `busy`, `groupDone`, `xferStart` and `suspended` are all 0.
- R2: A trigger loads the pointer with the start field of group `grpSel`. Each group's start field occupies `grpStarts[g*AW +: AW]`. The last entry of group g is the start field of group g+1 minus 1, and DEPTH-1 for the highest group. Entries are visited in ascending order, and `bufAddr` shows the entry being handled.
- R3: With `trigAlways`=1, a set `grpEnable` starts the group by itself. With `trigAlways`=0, the group starts only on a `trigPulse` while enabled and idle. A pulse that arrives while a run is in progress neither restarts nor disturbs it.
- R4: With `oneShot`=1, a finished group stays idle while `grpEnable` remains set, and it ignores further trigger pulses. Clearing and then setting `grpEnable` re-arms it.
- R5: With `oneShot`=0 and `trigAlways`=1, the group restarts at its first entry on its own. The restart transfer begins 3 cycles after the start of the previous run's last transfer.
- R6: The buffer mode is control-word bits 15:13. Mode 0 skips the entry: no transfer, no gap, and one cycle spent on the entry.
- R7: Mode 3'b100 stalls on the entry until `txFull` is 1, and `suspended` is 1 while it stalls.
- R8: Mode 3'b110 stalls until `txFull` and `rxEmpty` are both 1.
- R9: Modes 1, 2, 3, 5 and 7 send without waiting on either flag.
- R10: If control bit 10 is set, `wordDelay`+2 idle cycles follow the cycle in which `xferDone` is seen. If it is clear, the next entry is handled in the cycle right after the done cycle. With a one-cycle responder, transfer starts are therefore `wordDelay`+4 or 2 cycles apart.
- R11: `xferStart` is a single-cycle pulse. While it is high, `xferCs` = bits 7:0, `xferHold` = bit 12 and `xferFmt` = bits 9:8 of the entry's control word.
- R12: After the last entry finishes, `groupDone` goes to 1 and `busy` goes to 0. `groupDone` stays at 1 until the next trigger.
- R13: Clearing `grpEnable` during a run abandons it. `busy` falls on the next cycle and no further transfer starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| grpEnable | input | 1 | Enable of the selected group |
| grpSel | input | GW | Index of the group to run |
| grpStarts | input | NUM_GROUPS*AW | Packed start fields of all groups |
| trigAlways | input | 1 | 1: starting needs only the enable |
| trigPulse | input | 1 | External trigger pulse |
| oneShot | input | 1 | 1: run once per trigger |
| wordDelay | input | 8 | Gap length code |
| bufAddr | output | AW | Entry being handled |
| bufCtrl | input | 16 | Control word of entry `bufAddr` |
| txFull | input | 1 | Transmit data present for entry `bufAddr` |
| rxEmpty | input | 1 | Receive slot of entry `bufAddr` has been read |
| xferStart | output | 1 | Start one serial word |
| xferCs | output | 8 | Chip-select code of the word |
| xferHold | output | 1 | Keep chip select asserted after the word |
| xferFmt | output | 2 | Data-format select of the word |
| xferDone | input | 1 | Serial word finished |
| suspended | output | 1 | Stalled on the current entry |
| busy | output | 1 | A run is in progress |
| groupDone | output | 1 | Last run completed |

## Verification
The bench uses the default build: a 16-entry RAM split into four groups of 3, 4, 5 and 4 entries. The highest group's end is set by the RAM depth, and the lower groups' ends are set by a neighbour's start field. Every group is run in turn. All eight mode codes are swept over one entry in the middle of a group, and every one of the 256 gap codes is measured against the start-to-start spacing. The small groups keep the stall, abort, re-arm and continuous-restart scenarios short enough to check their exact cycle counts.

// File: rtl/tgSeqPkg.sv
package tgSeqPkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EVAL = 2'd1,
    ST_XFER = 2'd2,
    ST_GAP  = 2'd3
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic loadPtr;
    logic incPtr;
    logic loadGap;
    logic decGap;
  } seqStrobe_t;

  localparam logic [2:0] MODE_SKIP    = 3'b000;
  localparam logic [2:0] MODE_WAIT_TX = 3'b100;
  localparam logic [2:0] MODE_WAIT_TR = 3'b110;

  localparam int MODE_HI  = 15;
  localparam int MODE_LO  = 13;
  localparam int HOLD_BIT = 12;
  localparam int DLY_BIT  = 10;

endpackage

// File: rtl/tgSeqDatapath.sv
module tgSeqDatapath
  import tgSeqPkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int NUM_GROUPS = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int GW = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  seqStrobe_t               strobe,
  input  logic [GW-1:0]            grpSel,
  input  logic [NUM_GROUPS*AW-1:0] grpStarts,
  input  logic [7:0]               wordDelay,
  output logic [AW-1:0]            ptr,
  output logic                     atEnd,
  output logic                     gapZero
);

  localparam int CW = 9;

  logic [AW-1:0] endTab [NUM_GROUPS];
  logic [AW-1:0] startAddr;
  logic [AW-1:0] endAddr;
  logic [CW-1:0] gapCnt;

  // End of each group comes from its upper neighbour's start field
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gEnd
    if (g == NUM_GROUPS - 1) begin : gTop
      assign endTab[g] = AW'(DEPTH - 1);
    end else begin : gMid
      assign endTab[g] = grpStarts[(g+1)*AW +: AW] - AW'(1);
    end
  end

  assign startAddr = grpStarts[int'(grpSel)*AW +: AW];
  assign endAddr   = endTab[grpSel];
  assign atEnd     = (ptr == endAddr);
  assign gapZero   = (gapCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (strobe.loadPtr) begin
      ptr <= startAddr;
    end else if (strobe.incPtr) begin
      ptr <= ptr + AW'(1);
    end
  end

  // Counts wordDelay+1 down to 0: wordDelay+2 cycles in the gap state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      gapCnt <= '0;
    end else if (strobe.loadGap) begin
      gapCnt <= {1'b0, wordDelay} + CW'(1);
    end else if (strobe.decGap) begin
      gapCnt <= gapCnt - CW'(1);
    end
  end

  assert_load_start_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadPtr |=> ptr == $past(startAddr));

  assert_inc_in_range_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.incPtr |-> ptr < endAddr);

  assert_gap_count_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.decGap |=> gapCnt == $past(gapCnt) - CW'(1));

endmodule

// File: rtl/tgSeqCtrl.sv
module tgSeqCtrl
  import tgSeqPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        grpEnable,
  input  logic        trigAlways,
  input  logic        trigPulse,
  input  logic        oneShot,
  input  logic [15:0] bufCtrl,
  input  logic        txFull,
  input  logic        rxEmpty,
  input  logic        xferDone,
  input  logic        atEnd,
  input  logic        gapZero,
  output seqStrobe_t  strobe,
  output logic        xferStart,
  output logic        suspended,
  output logic        busy,
  output logic        groupDone
);

  seqState_t state, nextState;
  logic       spent;
  logic [2:0] mode;
  logic       waitCond;
  logic       advance;
  logic       finish;

  assign mode = bufCtrl[MODE_HI:MODE_LO];
  assign waitCond = ((mode == MODE_WAIT_TX) && !txFull) ||
                    ((mode == MODE_WAIT_TR) && (!txFull || !rxEmpty));
  assign busy = (state != ST_IDLE);

  always_comb begin
    strobe    = '0;
    nextState = state;
    xferStart = 1'b0;
    suspended = 1'b0;
    advance   = 1'b0;
    finish    = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (grpEnable && !spent && (trigAlways || trigPulse)) begin
          strobe.loadPtr = 1'b1;
          nextState      = ST_EVAL;
        end
      end
      ST_EVAL: begin
        if (mode == MODE_SKIP) begin
          advance = 1'b1;
        end else if (waitCond) begin
          suspended = 1'b1;
        end else begin
          xferStart = 1'b1;
          nextState = ST_XFER;
        end
      end
      ST_XFER: begin
        if (xferDone) begin
          if (bufCtrl[DLY_BIT]) begin
            strobe.loadGap = 1'b1;
            nextState      = ST_GAP;
          end else begin
            advance = 1'b1;
          end
        end
      end
      ST_GAP: begin
        if (gapZero) advance = 1'b1;
        else         strobe.decGap = 1'b1;
      end
      default: nextState = ST_IDLE;
    endcase
    if (advance) begin
      if (atEnd) begin
        finish    = 1'b1;
        nextState = ST_IDLE;
      end else begin
        strobe.incPtr = 1'b1;
        nextState     = ST_EVAL;
      end
    end
    // Dropping the enable abandons the run
    if (busy && !grpEnable) begin
      strobe    = '0;
      xferStart = 1'b0;
      suspended = 1'b0;
      finish    = 1'b0;
      nextState = ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      spent     <= 1'b0;
      groupDone <= 1'b0;
    end else begin
      state <= nextState;
      if (strobe.loadPtr) groupDone <= 1'b0;
      else if (finish)    groupDone <= 1'b1;
      if (!grpEnable)               spent <= 1'b0;
      else if (finish && oneShot)   spent <= 1'b1;
    end
  end

  assert_start_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    xferStart |=> !xferStart);

  assert_done_after_run_R12: assert property (@(posedge clk) disable iff (!rstN)
    $rose(groupDone) |-> $past(busy));

  assert_oneshot_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    (spent && grpEnable) |=> !busy);

  assert_abort_R13: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !grpEnable) |=> !busy);

endmodule

// File: rtl/tgSequencer.sv
module tgSequencer
  import tgSeqPkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int NUM_GROUPS = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int GW = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     grpEnable,
  input  logic [GW-1:0]            grpSel,
  input  logic [NUM_GROUPS*AW-1:0] grpStarts,
  input  logic                     trigAlways,
  input  logic                     trigPulse,
  input  logic                     oneShot,
  input  logic [7:0]               wordDelay,
  output logic [AW-1:0]            bufAddr,
  input  logic [15:0]              bufCtrl,
  input  logic                     txFull,
  input  logic                     rxEmpty,
  output logic                     xferStart,
  output logic [7:0]               xferCs,
  output logic                     xferHold,
  output logic [1:0]               xferFmt,
  input  logic                     xferDone,
  output logic                     suspended,
  output logic                     busy,
  output logic                     groupDone
);

  seqStrobe_t strobe;
  logic       atEnd;
  logic       gapZero;

  tgSeqCtrl uCtrl (
    .clk(clk), .rstN(rstN), .grpEnable(grpEnable), .trigAlways(trigAlways),
    .trigPulse(trigPulse), .oneShot(oneShot), .bufCtrl(bufCtrl),
    .txFull(txFull), .rxEmpty(rxEmpty), .xferDone(xferDone),
    .atEnd(atEnd), .gapZero(gapZero), .strobe(strobe),
    .xferStart(xferStart), .suspended(suspended), .busy(busy),
    .groupDone(groupDone)
  );

  tgSeqDatapath #(.DEPTH(DEPTH), .NUM_GROUPS(NUM_GROUPS)) uDp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .grpSel(grpSel),
    .grpStarts(grpStarts), .wordDelay(wordDelay), .ptr(bufAddr),
    .atEnd(atEnd), .gapZero(gapZero)
  );

  assign xferCs   = bufCtrl[7:0];
  assign xferHold = bufCtrl[HOLD_BIT];
  assign xferFmt  = bufCtrl[9:8];

endmodule

// File: tb/tb_tgSequencer.sv
`timescale 1ns/1ps
module tb_tgSequencer;

  localparam int DEPTH = 16;
  localparam int NG    = 4;
  localparam int AW    = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN = 1'b0, grpEnable = 1'b0, trigAlways = 1'b1, trigPulse = 1'b0, oneShot = 1'b1;
  logic [1:0] grpSel = '0;
  logic [7:0] wordDelay = '0;
  logic [NG*AW-1:0] grpStarts = {4'd12, 4'd7, 4'd3, 4'd0};
  logic [AW-1:0] bufAddr;
  logic [15:0] bufCtrl;
  logic txFull, rxEmpty, xferStart, xferHold, xferDone, suspended, busy, groupDone;
  logic [7:0] xferCs;
  logic [1:0] xferFmt;

  logic [15:0] ctrlMem [DEPTH];
  logic txMem [DEPTH];
  logic rxMem [DEPTH];
  assign bufCtrl = ctrlMem[bufAddr];
  assign txFull  = txMem[bufAddr];
  assign rxEmpty = rxMem[bufAddr];

  tgSequencer #(.DEPTH(DEPTH), .NUM_GROUPS(NG)) dut (
    .clk(clk), .rstN(rstN), .grpEnable(grpEnable), .grpSel(grpSel),
    .grpStarts(grpStarts), .trigAlways(trigAlways), .trigPulse(trigPulse),
    .oneShot(oneShot), .wordDelay(wordDelay), .bufAddr(bufAddr),
    .bufCtrl(bufCtrl), .txFull(txFull), .rxEmpty(rxEmpty),
    .xferStart(xferStart), .xferCs(xferCs), .xferHold(xferHold),
    .xferFmt(xferFmt), .xferDone(xferDone), .suspended(suspended),
    .busy(busy), .groupDone(groupDone)
  );

  int nChk = 0, nFail = 0, cyc = 0, logN = 0;
  int logAddr [64];
  int logCyc [64];
  logic [7:0] logCs [64];
  logic logHold [64];
  logic [1:0] logFmt [64];
  logic donePend = 1'b0;
  initial xferDone = 1'b0;

  int gStart [NG] = '{0, 3, 7, 12};

  function automatic int gEnd(int g);
    return (g == NG - 1) ? DEPTH - 1 : gStart[g+1] - 1;
  endfunction

  function automatic logic [15:0] mkCtrl(logic [2:0] m, logic den, int a);
    return {m, a[0], 1'b0, den, a[2:1], 8'(a * 13 + 5)};
  endfunction

  // Monitor and one-cycle responder
  always @(negedge clk) begin
    cyc++;
    xferDone = donePend;
    donePend = 1'b0;
    if (xferStart) begin
      if (logN < 64) begin
        logAddr[logN] = int'(bufAddr);
        logCyc[logN]  = cyc;
        logCs[logN]   = xferCs;
        logHold[logN] = xferHold;
        logFmt[logN]  = xferFmt;
      end
      logN++;
      donePend = 1'b1;
    end
  end

  task automatic chk(string req, int act, int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic fillAll(logic [2:0] m);
    for (int a = 0; a < DEPTH; a++) begin
      ctrlMem[a] = mkCtrl(m, 1'b0, a);
      txMem[a] = 1'b1;
      rxMem[a] = 1'b1;
    end
  endtask

  task automatic waitDone(int limit);
    for (int i = 0; i < limit && !groupDone; i++) tick(1);
  endtask

  // Runs group g in immediate one-shot mode and leaves it disabled
  task automatic runGroup(int g);
    grpSel = 2'(g);
    logN = 0;
    grpEnable = 1'b1;
    tick(1);
    waitDone(2000);
    tick(1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChk++;
    nFail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

  initial begin
    fillAll(3'b111);
    tick(3);
    chk("R1 busy", int'(busy), 0);
    chk("R1 groupDone", int'(groupDone), 0);
    chk("R1 xferStart", int'(xferStart), 0);
    chk("R1 suspended", int'(suspended), 0);
    rstN = 1'b1;
    tick(2);

    // R2 R11 R12: every group, plain sends, no gap
    for (int g = 0; g < NG; g++) begin
      runGroup(g);
      chk("R2 count", logN, gEnd(g) - gStart[g] + 1);
      for (int i = 0; i < logN && i < 64; i++) begin
        chk("R2 order", logAddr[i], gStart[g] + i);
        chk("R11 cs", int'(logCs[i]), (logAddr[i] * 13 + 5) % 256);
        chk("R11 hold", int'(logHold[i]), logAddr[i] % 2);
        chk("R11 fmt", int'(logFmt[i]), (logAddr[i] / 2) % 4);
        if (i > 0) chk("R10 no-gap spacing", logCyc[i] - logCyc[i-1], 2);
      end
      chk("R12 groupDone", int'(groupDone), 1);
      chk("R12 busy", int'(busy), 0);
      grpEnable = 1'b0;
      tick(2);
    end

    // R6 R9: sweep all mode codes on entry 4 of group 1
    for (int m = 0; m < 8; m++) begin
      fillAll(3'b001);
      ctrlMem[4] = mkCtrl(3'(m), 1'b0, 4);
      runGroup(1);
      if (m == 0) begin
        chk("R6 skip count", logN, 3);
        chk("R6 skip addr", logAddr[1], 5);
        chk("R6 skip spacing", logCyc[1] - logCyc[0], 3);
      end else begin
        chk("R9 send count", logN, 4);
        chk("R9 send addr", logAddr[1], 4);
      end
      grpEnable = 1'b0;
      tick(2);
    end

    // R10: every gap code
    fillAll(3'b001);
    ctrlMem[0] = mkCtrl(3'b001, 1'b1, 0);
    for (int w = 0; w < 256; w++) begin
      wordDelay = 8'(w);
      runGroup(0);
      chk("R10 count", logN, 3);
      chk("R10 gap spacing", logCyc[1] - logCyc[0], w + 4);
      chk("R10 after spacing", logCyc[2] - logCyc[1], 2);
      grpEnable = 1'b0;
      tick(2);
    end
    wordDelay = '0;

    // R7: stall on transmit-full
    fillAll(3'b001);
    ctrlMem[5] = mkCtrl(3'b100, 1'b0, 5);
    txMem[5] = 1'b0;
    grpSel = 2'd1; logN = 0; grpEnable = 1'b1;
    tick(20);
    chk("R7 stalled count", logN, 2);
    chk("R7 suspended", int'(suspended), 1);
    chk("R7 busy", int'(busy), 1);
    txMem[5] = 1'b1;
    waitDone(100);
    tick(1);
    chk("R7 resumed count", logN, 4);
    chk("R7 resumed addr", logAddr[2], 5);
    chk("R7 suspended clear", int'(suspended), 0);
    grpEnable = 1'b0;
    tick(2);

    // R8: stall needs both flags
    ctrlMem[5] = mkCtrl(3'b110, 1'b0, 5);
    txMem[5] = 1'b1; rxMem[5] = 1'b0;
    logN = 0; grpEnable = 1'b1;
    tick(20);
    chk("R8 rx stall count", logN, 2);
    chk("R8 rx suspended", int'(suspended), 1);
    rxMem[5] = 1'b1; txMem[5] = 1'b0;
    tick(10);
    chk("R8 tx stall count", logN, 2);
    chk("R8 tx suspended", int'(suspended), 1);
    txMem[5] = 1'b1;
    waitDone(100);
    tick(1);
    chk("R8 resumed count", logN, 4);
    grpEnable = 1'b0;
    tick(2);

    // R13: abort while stalled
    ctrlMem[5] = mkCtrl(3'b100, 1'b0, 5);
    txMem[5] = 1'b0;
    logN = 0; grpEnable = 1'b1;
    tick(10);
    grpEnable = 1'b0;
    tick(2);
    chk("R13 busy", int'(busy), 0);
    chk("R13 suspended", int'(suspended), 0);
    txMem[5] = 1'b1;
    tick(10);
    chk("R13 no more starts", logN, 2);

    // R3: external trigger
    trigAlways = 1'b0;
    fillAll(3'b001);
    ctrlMem[5] = mkCtrl(3'b100, 1'b0, 5);
    txMem[5] = 1'b0;
    logN = 0; grpEnable = 1'b1;
    tick(10);
    chk("R3 waits for pulse", int'(busy), 0);
    chk("R3 no start", logN, 0);
    trigPulse = 1'b1; tick(1); trigPulse = 1'b0;
    tick(10);
    chk("R3 started", int'(busy), 1);
    trigPulse = 1'b1; tick(1); trigPulse = 1'b0;
    tick(3);
    txMem[5] = 1'b1;
    waitDone(100);
    tick(1);
    chk("R3 busy pulse ignored count", logN, 4);
    chk("R3 busy pulse ignored addr", logAddr[2], 5);
    // R4: pulse after a one-shot run is ignored
    trigPulse = 1'b1; tick(1); trigPulse = 1'b0;
    tick(5);
    chk("R4 pulse ignored busy", int'(busy), 0);
    chk("R4 pulse ignored count", logN, 4);
    grpEnable = 1'b0;
    tick(2);
    trigAlways = 1'b1;

    // R4: immediate one-shot holds, re-arms on enable toggle
    fillAll(3'b001);
    runGroup(2);
    tick(10);
    chk("R4 held count", logN, 5);
    chk("R4 held busy", int'(busy), 0);
    grpEnable = 1'b0;
    tick(2);
    grpEnable = 1'b1;
    tick(1);
    waitDone(200);
    tick(1);
    chk("R4 rearmed count", logN, 10);
    grpEnable = 1'b0;
    tick(2);

    // R5: continuous restart
    oneShot = 1'b0;
    grpSel = 2'd0; logN = 0; grpEnable = 1'b1;
    for (int i = 0; i < 100 && logN < 6; i++) tick(1);
    grpEnable = 1'b0;
    tick(3);
    chk("R5 restart addr", logAddr[3], 0);
    chk("R5 restart spacing", logCyc[3] - logCyc[2], 3);
    chk("R5 stopped", int'(busy), 0);
    oneShot = 1'b1;

    $display("[TB] %0d tests run, %0d failed", nChk, nFail);
    $finish;
  end

endmodule